// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for load and store instructions on a 16-bit, byte-addressed, little-endian machine. It also produces the updated value of the base register when the addressing mode modifies it. The decode stage presents a request with these inputs:

- the base register value
- a 3-bit mode code
- a byte/word size flag
- a 7-bit offset field

One clock later the unit returns:

- the address
- a memory strobe
- the new base value and its write enable
- a misalignment flag
- the byte lanes the access touches

The supported modes are:

- plain register-indirect
- increment or decrement of the base, either before or after the access
- a relative form that adds a sign-extended 7-bit offset to the base

The increment or decrement step follows the access size, so one mode code serves both byte and word indexed walks. Pre-decrement of the stack pointer on a word store is a push. Post-increment on a word load is a pull. A word access at an odd address is stopped: the unit sets the misalignment flag and drops both the strobe and the base writeback.

Top module: `lsea_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Outputs are registered one clock after a request. A cycle with req_i low gives mem_req_o, base_we_o and misalign_o low on the next cycle.
- R3: Mode code 0 (register-indirect) gives addr_o equal to the base, with base_we_o low and base_wr_o equal to the base.
- R4: Mode codes 1 (post-increment) and 2 (post-decrement) address the unmodified base. They write back base plus or minus the step, with base_we_o high.
- R5: Mode codes 3 (pre-increment) and 4 (pre-decrement) write back base plus or minus the step. The address equals that new value.
- R6: The step is 2 when byte_i is 0 (word access) and 1 when byte_i is 1 (byte access).
- R7: Mode code 5 (relative) gives the address as base plus the 7-bit two's-complement offset sign-extended to 16 bits. It never asserts base_we_o.
- R8: A word access whose address has bit 0 set raises misalign_o and holds mem_req_o and base_we_o low.
- R9: lane_o bit 0 marks the even (low) byte and bit 1 marks the odd (high) byte. A word access gives 2'b11. A byte access gives 2'b01 at an even address and 2'b10 at an odd address. lane_o is 2'b00 whenever mem_req_o is low.
- R10: Mode codes 6 and 7 are reserved. They give no strobe, no writeback and no misalignment, and addr_o equals the base.
- R11: All address arithmetic wraps modulo 65536. For example, pre-decrementing a word base of 0x0000 gives 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Load/store address request |
| mode_i | input | 3 | Addressing mode code |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| base_i | input | 16 | Base register value |
| offset_i | input | 7 | Signed relative offset |
| mem_req_o | output | 1 | Memory access strobe |
| addr_o | output | 16 | Effective byte address |
| base_wr_o | output | 16 | Updated base value |
| base_we_o | output | 1 | Base register write enable |
| misalign_o | output | 1 | Word access at an odd address |
| lane_o | output | 2 | Byte lane selects |

## Verification
On every cycle, properties check the following:

- Indirect and post modes address the base as it was presented.
- Pre modes address exactly the written-back value.
- Relative mode never writes back.
- A strobe never coexists with misalignment.
- Lanes are empty without a strobe and full for any word strobe.

The exact arithmetic needs the bench's directed scenarios:

- the size-dependent step
- sign extension of negative offsets
- wrap-around at both ends of the address space
- byte lane choice by address parity
- the treatment of reserved codes

// File: rtl/lsea_pkg.sv
package lsea_pkg;
  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] AM_REG     = 3'd0;
  localparam logic [MODE_W-1:0] AM_POSTINC = 3'd1;
  localparam logic [MODE_W-1:0] AM_POSTDEC = 3'd2;
  localparam logic [MODE_W-1:0] AM_PREINC  = 3'd3;
  localparam logic [MODE_W-1:0] AM_PREDEC  = 3'd4;
  localparam logic [MODE_W-1:0] AM_REL     = 3'd5;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/lsea_adjust.sv
module lsea_adjust #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic          byte_i,
  output logic [AW-1:0] inc_o,
  output logic [AW-1:0] dec_o
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] step;

  assign step  = byte_i ? STEP_B : STEP_W;
  assign inc_o = base_i + step;
  assign dec_o = base_i - step;
endmodule

// File: rtl/lsea_reladd.sv
module lsea_reladd #(
  parameter int unsigned AW   = 16,
  parameter int unsigned OFFW = 7
) (
  input  logic [AW-1:0]   base_i,
  input  logic [OFFW-1:0] off_i,
  output logic [AW-1:0]   addr_o
);
  localparam int unsigned EXTW = AW - OFFW;

  logic [AW-1:0] off_sx;

  assign off_sx = {{EXTW{off_i[OFFW-1]}}, off_i};
  assign addr_o = base_i + off_sx;
endmodule

// File: rtl/lsea_lanes.sv
module lsea_lanes
  import lsea_pkg::*;
(
  input  logic             en_i,
  input  logic             byte_i,
  input  logic             addr_lsb_i,
  output logic             misalign_o,
  output logic [LANES-1:0] lane_o
);
  logic go;

  assign misalign_o = en_i & ~byte_i & addr_lsb_i;
  assign go         = en_i & ~misalign_o;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // word: all lanes; byte: lane matching address parity
    assign lane_o[g] = go & (~byte_i | (addr_lsb_i == g[0]));
  end
endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
  import lsea_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned OFFW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              byte_i,
  input  logic [AW-1:0]     base_i,
  input  logic [OFFW-1:0]   offset_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     base_wr_o,
  output logic              base_we_o,
  output logic              misalign_o,
  output logic [LANES-1:0]  lane_o
);
  logic [AW-1:0]    inc, dec, rel;
  logic [AW-1:0]    addr_c, nb_c;
  logic             wb_c, valid_c, en_c, mis_c;
  logic [LANES-1:0] lane_c;

  lsea_adjust #(.AW(AW)) u_adjust (
    .base_i (base_i),
    .byte_i (byte_i),
    .inc_o  (inc),
    .dec_o  (dec)
  );

  lsea_reladd #(.AW(AW), .OFFW(OFFW)) u_reladd (
    .base_i (base_i),
    .off_i  (offset_i),
    .addr_o (rel)
  );

  always_comb begin
    addr_c  = base_i;
    nb_c    = base_i;
    wb_c    = 1'b0;
    valid_c = 1'b1;
    case (mode_i)
      AM_REG: ;
      AM_POSTINC: begin nb_c = inc; wb_c = 1'b1; end
      AM_POSTDEC: begin nb_c = dec; wb_c = 1'b1; end
      AM_PREINC:  begin nb_c = inc; addr_c = inc; wb_c = 1'b1; end
      AM_PREDEC:  begin nb_c = dec; addr_c = dec; wb_c = 1'b1; end
      AM_REL:     addr_c = rel;
      default:    valid_c = 1'b0;
    endcase
  end

  assign en_c = req_i & valid_c;

  lsea_lanes u_lanes (
    .en_i       (en_c),
    .byte_i     (byte_i),
    .addr_lsb_i (addr_c[0]),
    .misalign_o (mis_c),
    .lane_o     (lane_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o  <= 1'b0;
      addr_o     <= '0;
      base_wr_o  <= '0;
      base_we_o  <= 1'b0;
      misalign_o <= 1'b0;
      lane_o     <= '0;
    end else begin
      mem_req_o  <= en_c & ~mis_c;
      addr_o     <= addr_c;
      base_wr_o  <= nb_c;
      base_we_o  <= en_c & wb_c & ~mis_c;
      misalign_o <= mis_c;
      lane_o     <= lane_c;
    end
  end

  a_r3_indirect_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == AM_REG) |=> (addr_o == $past(base_i) && !base_we_o));

  a_r4_post_uses_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mode_i == AM_POSTINC || mode_i == AM_POSTDEC)) |=> (addr_o == $past(base_i)));

  a_r5_pre_addr_eq_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mode_i == AM_PREINC || mode_i == AM_PREDEC)) |=> (addr_o == base_wr_o));

  a_r7_rel_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == AM_REL) |=> !base_we_o);

  a_r8_no_strobe_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !misalign_o);

  a_r8_no_wb_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !base_we_o);

  a_r9_idle_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (lane_o == '0));

  a_r9_word_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !$past(byte_i)) |-> (lane_o == {LANES{1'b1}}));

  a_r2_wb_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |-> mem_req_o);
endmodule

// File: tb/lsea_unit_bench.sv
module lsea_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] base_i = '0;
  logic [6:0]  offset_i = '0;
  logic        mem_req_o, base_we_o, misalign_o;
  logic [15:0] addr_o, base_wr_o;
  logic [1:0]  lane_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lsea_unit u_lsea_unit (
    .clk_i, .rst_ni, .req_i, .mode_i, .byte_i, .base_i, .offset_i,
    .mem_req_o, .addr_o, .base_wr_o, .base_we_o, .misalign_o, .lane_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] m, input logic b, input logic [15:0] base,
                    input logic [6:0] off);
    @(negedge clk_i);
    req_i = 1'b1; mode_i = m; byte_i = b; base_i = base; offset_i = off;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic mr, input logic [15:0] a,
                            input logic [15:0] nb, input logic we, input logic mis,
                            input logic [1:0] ln);
    chk({tag, " strobe"}, 32'(mem_req_o), 32'(mr));
    chk({tag, " addr"}, 32'(addr_o), 32'(a));
    chk({tag, " base_wr"}, 32'(base_wr_o), 32'(nb));
    chk({tag, " base_we"}, 32'(base_we_o), 32'(we));
    chk({tag, " misalign"}, 32'(misalign_o), 32'(mis));
    chk({tag, " lanes"}, 32'(lane_o), 32'(ln));
  endtask

  task automatic t_reset;
    #5;
    expect_all("R1 reset", 0, 16'h0, 16'h0, 0, 0, 2'b00);
  endtask

  task automatic t_indirect;
    op(3'd0, 0, 16'h1234, 7'h0);
    expect_all("R3 indirect word", 1, 16'h1234, 16'h1234, 0, 0, 2'b11);
  endtask

  task automatic t_post;
    op(3'd1, 0, 16'h0100, 7'h0);
    expect_all("R4 R6 postinc word", 1, 16'h0100, 16'h0102, 1, 0, 2'b11);
    op(3'd2, 1, 16'h0051, 7'h0);
    expect_all("R4 R6 R9 postdec byte odd", 1, 16'h0051, 16'h0050, 1, 0, 2'b10);
    op(3'd1, 0, 16'h0FFE, 7'h0);
    expect_all("R4 pull", 1, 16'h0FFE, 16'h1000, 1, 0, 2'b11);
  endtask

  task automatic t_pre;
    op(3'd4, 0, 16'h1000, 7'h0);
    expect_all("R5 push predec word", 1, 16'h0FFE, 16'h0FFE, 1, 0, 2'b11);
    op(3'd3, 1, 16'h00FF, 7'h0);
    expect_all("R5 R6 R9 preinc byte even", 1, 16'h0100, 16'h0100, 1, 0, 2'b01);
  endtask

  task automatic t_rel;
    op(3'd5, 0, 16'h2000, 7'h40);
    expect_all("R7 rel -64", 1, 16'h1FC0, 16'h2000, 0, 0, 2'b11);
    op(3'd5, 1, 16'h2000, 7'h3F);
    expect_all("R7 R9 rel +63 byte", 1, 16'h203F, 16'h2000, 0, 0, 2'b10);
    op(3'd5, 0, 16'h0010, 7'h60);
    expect_all("R7 R11 rel wrap", 1, 16'hFFF0, 16'h0010, 0, 0, 2'b11);
  endtask

  task automatic t_misalign;
    op(3'd1, 0, 16'h0101, 7'h0);
    expect_all("R8 postinc odd word", 0, 16'h0101, 16'h0103, 0, 1, 2'b00);
    op(3'd5, 0, 16'h2000, 7'h3F);
    expect_all("R8 rel odd word", 0, 16'h203F, 16'h2000, 0, 1, 2'b00);
  endtask

  task automatic t_reserved;
    op(3'd6, 0, 16'h0101, 7'h0);
    expect_all("R10 code6", 0, 16'h0101, 16'h0101, 0, 0, 2'b00);
    op(3'd7, 1, 16'h4444, 7'h0);
    expect_all("R10 code7", 0, 16'h4444, 16'h4444, 0, 0, 2'b00);
  endtask

  task automatic t_wrap;
    op(3'd4, 0, 16'h0000, 7'h0);
    expect_all("R11 predec wrap", 1, 16'hFFFE, 16'hFFFE, 1, 0, 2'b11);
    op(3'd3, 1, 16'hFFFF, 7'h0);
    expect_all("R11 preinc wrap", 1, 16'h0000, 16'h0000, 1, 0, 2'b01);
  endtask

  task automatic t_idle;
    op(3'd1, 0, 16'h0200, 7'h0);
    @(negedge clk_i);
    chk("R2 idle strobe", 32'(mem_req_o), 0);
    chk("R2 idle base_we", 32'(base_we_o), 0);
    chk("R2 idle misalign", 32'(misalign_o), 0);
  endtask

  initial begin
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_indirect();
    t_post();
    t_pre();
    t_rel();
    t_misalign();
    t_reserved();
    t_wrap();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule